// File: doc/BRIEF.md
# NAND Flash Page and Cache Read Sequencer

This block sits on the host side of an 8-bit NAND flash bus and runs read operations only. User logic hands it one request at a time: an operation code, a row address, a column address and a byte count. The sequencer produces the command-latch and address-latch cycles with a write strobe of programmable width. It waits on the ready/busy line wherever the flash needs array time, pulses the read strobe once per byte, and returns the bytes on a valid/ready stream.

Four operations are supported. A full page open loads a row into the flash. A column jump moves the read pointer inside the page that is already open. A cache step moves the next page into the cache register and starts the following array read. A cache finish moves the last page over without starting another array read. A request that does not fit the current state is accepted and dropped, with no bus cycles. A ready/busy wait that runs longer than a programmable limit raises an error flag, closes the page and returns the sequencer to idle. All bus timing is counted in system clocks.

Top module: `nand_rd_seq`

## Requirements
- R1: Command bytes are latched with `nand_cle` high and address bytes with `nand_ale` high, never both at once. On each latch cycle `nand_we_n` is low for `cfg_we_clks` clocks (a value of 0 counts as 1), then high for the same number, with `nand_dq_oe` high throughout.
- R2: Op code 0 (page open) latches 00h, then the column low byte, the column high byte, and the row bytes 0, 1 and 2 (least significant first), then 30h.
- R3: After 30h, 31h or 3Fh, `nand_re_n` stays high until a guard of TWB_CLKS clocks has passed and `nand_rb` is high.
- R4: Each read strobe returns the next sequential byte. A page open delivers `req_len` bytes starting at `req_col`, in order, on the `rd_valid`/`rd_ready` stream.
- R5: Op code 1 (column jump) latches 05h, column low, column high and E0h, then reads `req_len` bytes from the new column without a busy wait. It may be repeated any number of times. When no page is open, it is accepted and dropped with no bus cycles.
- R6: Op code 2 (cache step) latches the single command 31h with no address bytes. After the busy wait it reads `req_len` bytes from column 0 of the page moved into the cache register, and `req_col` is ignored.
- R7: Op code 3 (cache finish) latches the single command 3Fh and reads the final page from column 0. It ends the cache sequence: op codes 2 and 3 are then dropped with no bus cycles until the next page open.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. A new read strobe starts only when the output register is empty or is being emptied in that cycle.
- R9: If `nand_rb` stays low for more than `cfg_busy_tmo` clocks after the guard, `err_timeout` goes high, the sequencer returns to idle with no read strobes, and the page is closed. `err_timeout` clears when the next request is accepted.
- R10: A request with `req_len` of 0 performs its latch cycles, and its busy wait where one applies, and produces no read strobe.
- R11: After reset `nand_cle`, `nand_ale`, `nand_dq_oe`, `rd_valid` and `err_timeout` are low, `nand_we_n` and `nand_re_n` are high, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_clks | input | WE_W | Write strobe low and high width in clocks |
| cfg_busy_tmo | input | TMO_W | Ready/busy timeout in clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_op | input | 2 | 0 page open, 1 column jump, 2 cache step, 3 cache finish |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_len | input | LEN_W | Number of bytes to read |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Read byte |
| err_timeout | output | 1 | Busy wait exceeded the limit |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven toward the flash |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus byte from the flash |
| nand_rb | input | 1 | Ready (1) or busy (0) |

## Verification
Two functions can meet in one cycle. The first is the consumer taking the last byte of one request. The second is either the sequencer accepting and latching the next request, or starting the next read strobe. The bench drives `rd_ready` from a pseudo-random pattern and issues each request as soon as the sequencer is idle, so bytes from one request are often still waiting while the next request's command cycles run. A scoreboard that is filled in request order judges the result. It checks that no byte is lost, duplicated or reordered across request boundaries, and a separate check confirms that a held byte stays stable under backpressure.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    typedef enum logic [1:0] {
        OP_PAGE   = 2'd0,
        OP_COLSEL = 2'd1,
        OP_CNEXT  = 2'd2,
        OP_CLAST  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_BUSY,
        ST_READ
    } st_e;

    localparam logic [7:0] CMD_OPEN_A  = 8'h00;
    localparam logic [7:0] CMD_OPEN_B  = 8'h30;
    localparam logic [7:0] CMD_JUMP_A  = 8'h05;
    localparam logic [7:0] CMD_JUMP_B  = 8'hE0;
    localparam logic [7:0] CMD_CSTEP   = 8'h31;
    localparam logic [7:0] CMD_CFINISH = 8'h3F;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
        logic       last;
    } lat_t;

endpackage

// File: rtl/nand_rd_busywait.sv
module nand_rd_busywait #(
    parameter int TWB_CLKS = 4,
    parameter int TMO_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rb,
    input  logic [TMO_W-1:0] lim,
    output logic             done,
    output logic             expired
);
    localparam int GW = $clog2(TWB_CLKS + 1);

    typedef struct packed {
        logic             act;
        logic [GW-1:0]    g;
        logic [TMO_W-1:0] t;
    } w_t;

    w_t w_d, w_q;
    logic guard_ok;

    assign guard_ok = (w_q.g == GW'(TWB_CLKS));
    assign done     = w_q.act && guard_ok && rb;
    assign expired  = w_q.act && guard_ok && !rb && (w_q.t >= lim);

    always_comb begin
        w_d = w_q;
        if (start) begin
            w_d.act = 1'b1;
            w_d.g   = '0;
            w_d.t   = '0;
        end else if (done || expired) begin
            w_d.act = 1'b0;
        end else if (w_q.act) begin
            if (!guard_ok) w_d.g = w_q.g + 1'b1;
            else           w_d.t = w_q.t + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nand_rd_pkg::*;
#(
    parameter int ROW_W    = 24,
    parameter int COL_W    = 16,
    parameter int LEN_W    = 16,
    parameter int WE_W     = 4,
    parameter int TMO_W    = 16,
    parameter int TWB_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WE_W-1:0]  cfg_we_clks,
    input  logic [TMO_W-1:0] cfg_busy_tmo,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             err_timeout,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);
    localparam int COL_BYTES = (COL_W + 7) / 8;
    localparam int ROW_BYTES = (ROW_W + 7) / 8;
    localparam int MAX_STEPS = 2 + COL_BYTES + ROW_BYTES;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    typedef struct packed {
        st_e              st;
        op_e              op;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] left;
        logic [STEP_W-1:0] step;
        logic             ph;
        logic             pul;
        logic [WE_W-1:0]  cnt;
        logic             open_pg;
        logic             cache_on;
        logic             err;
        logic             rvalid;
        logic [7:0]       rdata;
    } regs_t;

    regs_t s_d, s_q;
    lat_t  it;
    logic  legal, wait_go, w_done, w_exp, cnt_end;
    logic [WE_W-1:0] we_len;

    // Byte sent on a given latch step of an operation
    function automatic lat_t latch_item(op_e op, logic [STEP_W-1:0] step,
                                        logic [ROW_W-1:0] row, logic [COL_W-1:0] col);
        lat_t r;
        int   s;
        r = '0;
        s = int'(step);
        case (op)
            OP_PAGE: begin
                if (s == 0) begin
                    r.is_cmd = 1'b1; r.val = CMD_OPEN_A;
                end else if (s <= COL_BYTES) begin
                    r.val = 8'(col >> (8 * (s - 1)));
                end else if (s <= COL_BYTES + ROW_BYTES) begin
                    r.val = 8'(row >> (8 * (s - 1 - COL_BYTES)));
                end else begin
                    r.is_cmd = 1'b1; r.val = CMD_OPEN_B; r.last = 1'b1;
                end
            end
            OP_COLSEL: begin
                if (s == 0) begin
                    r.is_cmd = 1'b1; r.val = CMD_JUMP_A;
                end else if (s <= COL_BYTES) begin
                    r.val = 8'(col >> (8 * (s - 1)));
                end else begin
                    r.is_cmd = 1'b1; r.val = CMD_JUMP_B; r.last = 1'b1;
                end
            end
            OP_CNEXT: begin
                r.is_cmd = 1'b1; r.val = CMD_CSTEP; r.last = 1'b1;
            end
            default: begin
                r.is_cmd = 1'b1; r.val = CMD_CFINISH; r.last = 1'b1;
            end
        endcase
        return r;
    endfunction

    assign we_len  = (cfg_we_clks == '0) ? WE_W'(1) : cfg_we_clks;
    assign cnt_end = (s_q.cnt == we_len - 1'b1);
    assign it      = latch_item(s_q.op, s_q.step, s_q.row, s_q.col);

    always_comb begin
        case (op_e'(req_op))
            OP_PAGE:   legal = 1'b1;
            OP_COLSEL: legal = s_q.open_pg;
            default:   legal = s_q.open_pg && s_q.cache_on;
        endcase
    end

    nand_rd_busywait #(
        .TWB_CLKS (TWB_CLKS),
        .TMO_W    (TMO_W)
    ) wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wait_go),
        .rb      (nand_rb),
        .lim     (cfg_busy_tmo),
        .done    (w_done),
        .expired (w_exp)
    );

    always_comb begin
        s_d     = s_q;
        wait_go = 1'b0;
        if (s_q.rvalid && rd_ready) s_d.rvalid = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.err  = 1'b0;
                    s_d.op   = op_e'(req_op);
                    s_d.row  = req_row;
                    s_d.col  = req_col;
                    s_d.left = req_len;
                    s_d.step = '0;
                    s_d.ph   = 1'b0;
                    s_d.pul  = 1'b0;
                    s_d.cnt  = '0;
                    if (legal) s_d.st = ST_LATCH;
                end
            end
            ST_LATCH: begin
                if (cnt_end) begin
                    s_d.cnt = '0;
                    s_d.ph  = ~s_q.ph;
                    if (s_q.ph) begin
                        if (it.last) begin
                            if (s_q.op == OP_COLSEL) begin
                                s_d.st = (s_q.left == '0) ? ST_IDLE : ST_READ;
                            end else begin
                                s_d.st  = ST_BUSY;
                                wait_go = 1'b1;
                            end
                        end else begin
                            s_d.step = s_q.step + 1'b1;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_BUSY: begin
                if (w_done) begin
                    if (s_q.op == OP_PAGE) begin
                        s_d.open_pg  = 1'b1;
                        s_d.cache_on = 1'b1;
                    end
                    if (s_q.op == OP_CLAST) s_d.cache_on = 1'b0;
                    s_d.st = (s_q.left == '0) ? ST_IDLE : ST_READ;
                end else if (w_exp) begin
                    s_d.err      = 1'b1;
                    s_d.open_pg  = 1'b0;
                    s_d.cache_on = 1'b0;
                    s_d.st       = ST_IDLE;
                end
            end
            default: begin
                if (!s_q.pul) begin
                    if (!s_q.rvalid || rd_ready) begin
                        s_d.pul = 1'b1;
                        s_d.ph  = 1'b0;
                        s_d.cnt = '0;
                    end
                end else if (cnt_end) begin
                    s_d.cnt = '0;
                    if (!s_q.ph) begin
                        s_d.ph     = 1'b1;
                        s_d.rdata  = nand_dq_in;
                        s_d.rvalid = 1'b1;
                    end else begin
                        s_d.pul  = 1'b0;
                        s_d.ph   = 1'b0;
                        s_d.left = s_q.left - 1'b1;
                        if (s_q.left == LEN_W'(1)) s_d.st = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.op <= OP_PAGE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign rd_valid    = s_q.rvalid;
    assign rd_data     = s_q.rdata;
    assign err_timeout = s_q.err;
    assign nand_cle    = (s_q.st == ST_LATCH) && it.is_cmd;
    assign nand_ale    = (s_q.st == ST_LATCH) && !it.is_cmd;
    assign nand_we_n   = !((s_q.st == ST_LATCH) && !s_q.ph);
    assign nand_dq_out = it.val;
    assign nand_dq_oe  = (s_q.st == ST_LATCH);
    assign nand_re_n   = !((s_q.st == ST_READ) && s_q.pul && !s_q.ph);
endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       err_timeout,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       nand_rb
);
    p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_we_in_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> ((nand_cle || nand_ale) && nand_dq_oe));

    p_re_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (nand_rb && !nand_cle && !nand_ale));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_strobe_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(!rd_valid || rd_ready));

    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (req_ready && nand_re_n));
endmodule

bind nand_rd_seq nand_rd_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .err_timeout (err_timeout),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe),
    .nand_rb     (nand_rb)
);

// File: tb/nand_rd_seq_tb_top.sv
module nand_rd_seq_tb_top;
    localparam int BUSY_N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_we_clks = 4'd2;
    logic [15:0] cfg_busy_tmo = 16'd200;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic [15:0] req_len = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        err_timeout;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nand_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_clks(cfg_we_clks), .cfg_busy_tmo(cfg_busy_tmo),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .err_timeout(err_timeout), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    function automatic logic [7:0] fbyte(logic [23:0] pg, logic [15:0] c);
        return (pg[7:0] ^ c[7:0]) + (c[15:8] ^ pg[15:8]) + 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [23:0] m_pc, m_pd;
    logic [15:0] m_col;
    logic [7:0]  abuf [0:7];
    int          acnt, m_busy, we_low, re_falls;
    bit          stuck = 0;
    logic        we_prev, re_prev;
    logic [8:0]  lat_log [$];

    assign nand_rb    = (m_busy == 0) && !stuck;
    assign nand_dq_in = fbyte(m_pc, m_col);

    always @(negedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_pd = '0; m_col = '0; acnt = 0; m_busy = 0;
            we_low = 0; re_falls = 0; we_prev = 1'b1; re_prev = 1'b1;
        end else begin
            if (m_busy > 0) m_busy--;
            if (!nand_we_n) we_low++;
            if (!we_prev && nand_we_n) begin
                check(we_low == ((cfg_we_clks == 0) ? 1 : int'(cfg_we_clks)), "R1",
                      "write strobe low width", we_low, int'(cfg_we_clks));
                we_low = 0;
                lat_log.push_back({nand_cle, nand_dq_out});
                if (nand_cle) begin
                    case (nand_dq_out)
                        8'h00, 8'h05: acnt = 0;
                        8'h30: begin
                            m_col = {abuf[1], abuf[0]};
                            m_pd  = {abuf[4], abuf[3], abuf[2]};
                            m_pc  = m_pd;
                            m_busy = BUSY_N;
                        end
                        8'hE0: m_col = {abuf[1], abuf[0]};
                        8'h31: begin m_pc = m_pd; m_pd = m_pd + 1; m_col = 0; m_busy = BUSY_N; end
                        8'h3F: begin m_pc = m_pd; m_col = 0; m_busy = BUSY_N; end
                        default: ;
                    endcase
                end else if (nand_ale && acnt < 8) begin
                    abuf[acnt] = nand_dq_out;
                    acnt++;
                end
            end
            if (re_prev && !nand_re_n) re_falls++;
            if (!re_prev && nand_re_n) m_col = m_col + 1;
            if (!nand_re_n && !nand_rb) check(0, "R3", "read strobe while busy", 0, 1);
            we_prev = nand_we_n;
            re_prev = nand_re_n;
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic [7:0] exp_q [$];
    bit         bp_on = 0;
    logic [7:0] lfsr = 8'hA5;
    logic       held_v = 0;
    logic [7:0] held_d = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v) check(rd_valid && rd_data == held_d, "R8", "held byte changed",
                              {rd_valid, rd_data}, {1'b1, held_d});
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rd_ready = bp_on ? lfsr[0] : 1'b1;
            held_v = rd_valid && !rd_ready;
            held_d = rd_data;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) check(0, "R4", "unexpected byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R4", "stream byte", rd_data, e);
                end
            end
        end
    end

    // ---------------- driver ----------------
    bit t_open = 0, t_cache = 0;
    logic [23:0] t_pc = '0, t_pd = '0;

    task automatic run_op(input int op, input logic [23:0] row, input logic [15:0] col,
                          input logic [15:0] len, input bit tmo, input string req);
        logic [8:0] el [$];
        bit legal;
        int rf0;
        logic [15:0] c0;
        legal = (op == 0) || (op == 1 && t_open) || (op >= 2 && t_open && t_cache);
        c0 = 16'h0;
        if (legal) begin
            case (op)
                0: begin
                    el = '{9'h100, {1'b0, col[7:0]}, {1'b0, col[15:8]}, {1'b0, row[7:0]},
                           {1'b0, row[15:8]}, {1'b0, row[23:16]}, 9'h130};
                    if (tmo) begin t_open = 0; t_cache = 0; end
                    else begin t_pc = row; t_pd = row; t_open = 1; t_cache = 1; end
                    c0 = col;
                end
                1: begin el = '{9'h105, {1'b0, col[7:0]}, {1'b0, col[15:8]}, 9'h1E0}; c0 = col; end
                2: begin el = '{9'h131}; t_pc = t_pd; t_pd = t_pd + 1; end
                default: begin el = '{9'h13F}; t_pc = t_pd; t_cache = 0; end
            endcase
            if (!tmo) for (int i = 0; i < int'(len); i++) exp_q.push_back(fbyte(t_pc, c0 + 16'(i)));
        end
        lat_log.delete();
        rf0 = re_falls;
        @(negedge clk);
        req_op = 2'(op); req_row = row; req_col = col; req_len = len; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        check(lat_log.size() == el.size(), req, "latched byte count", lat_log.size(), el.size());
        for (int i = 0; i < el.size() && i < lat_log.size(); i++)
            check(lat_log[i] == el[i], req, "latched byte", lat_log[i], el[i]);
        if (!legal || len == 0 || tmo)
            check(re_falls == rf0, req, "read strobes", re_falls - rf0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe
              && !rd_valid && !err_timeout, "R11", "reset state",
              {req_ready, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, rd_valid, err_timeout},
              8'b10011000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_op(1, 24'h0, 16'h0040, 16'd4, 0, "R5");       // no page open: dropped
        run_op(0, 24'h012345, 16'h0010, 16'd6, 0, "R2");  // page open, R4 bytes
        run_op(1, 24'h0, 16'h0200, 16'd4, 0, "R5");
        run_op(1, 24'h0, 16'h07FF, 16'd3, 0, "R5");
        run_op(2, 24'h0, 16'h1234, 16'd5, 0, "R6");
        run_op(2, 24'h0, 16'h0000, 16'd3, 0, "R6");
        bp_on = 1;
        run_op(2, 24'h0, 16'h0000, 16'd8, 0, "R8");
        run_op(3, 24'h0, 16'h0000, 16'd4, 0, "R7");
        run_op(2, 24'h0, 16'h0000, 16'd4, 0, "R7");       // after finish: dropped
        bp_on = 0;
        run_op(0, 24'h00ABCD, 16'h0003, 16'd0, 0, "R10");
        cfg_we_clks = 4'd1;
        bp_on = 1;
        run_op(0, 24'h00F00F, 16'h0100, 16'd5, 0, "R1");
        run_op(1, 24'h0, 16'h0008, 16'd3, 0, "R5");
        bp_on = 0;
        cfg_we_clks = 4'd0;
        run_op(2, 24'h0, 16'h0000, 16'd2, 0, "R1");       // width 0 acts as 1
        cfg_we_clks = 4'd2;
        cfg_busy_tmo = 16'd40;
        stuck = 1;
        run_op(0, 24'h000777, 16'h0000, 16'd2, 1, "R9");
        check(err_timeout == 1'b1, "R9", "timeout flag", err_timeout, 1);
        stuck = 0;
        run_op(1, 24'h0, 16'h0000, 16'd2, 0, "R9");       // page closed: dropped
        check(err_timeout == 1'b0, "R9", "flag cleared on accept", err_timeout, 0);
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R4", "bytes outstanding", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule